// File: doc/BRIEF.md
# Byte-laned asynchronous SRAM controller

This block sits between a simple synchronous host port and an asynchronous static memory of 131072 words by 32 bits. It turns each host request into the select, write-strobe and output-enable sequence that the memory needs. The memory is split into four byte lanes. Each lane has its own active-low select and active-low write strobe, and all lanes share one address bus and one output enable. Any mix of lanes can take part in one access, chosen by the host's byte-enable bits.

For a write, the controller holds the selects of the enabled lanes low for the whole access. It drives the data, pulses the write strobes low for a fixed number of cycles, and then raises them while the select, address and data stay put. The rising strobe edge therefore ends the write. For a read, the controller first lets its own data drivers rest for a turnaround gap. It then drops output enable for a fixed number of cycles and captures the bus on the edge that closes the window. Every access ends with a one-cycle done pulse. Requests that arrive while an access is running are dropped.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is asserted and right after it, every lane select and write strobe is high (inactive), output enable is high, the data drivers are off and done is low.
- R2: A write stores the write-data bytes whose byte-enable bit is set at the given word address. Byte-enable bit i covers data bits 8*i+7 to 8*i. Lanes with a clear bit keep their old contents.
- R3: A lane's write strobe is low only while that lane's select is low. It stays low for exactly WR_CYC cycles, and it rises at least one cycle before the select rises.
- R4: The controller never drives the data bus while output enable is low, and output enable is never low while any write strobe is low.
- R5: Output enable falls only after the data drivers have been off for at least TURN_CYC cycles.
- R6: On the cycle a write strobe rises, the address and the driven data equal their values of the cycle before, and the drivers are still on.
- R7: A read holds output enable low for RD_CYC cycles. It returns the memory bytes of the enabled lanes on the read data bus and zero in the bytes of disabled lanes. The value holds until the next read completes.
- R8: Done is high for exactly one cycle per access. It is first seen WR_CYC+2 cycles after the accepting edge for a write, and TURN_CYC+RD_CYC+1 cycles after it for a read.
- R9: A request that is raised while an access is in progress is ignored. It causes no extra done pulse and no memory change.
- R10: The selects of lanes whose byte-enable bit is clear stay high for the whole access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Access request, taken when the controller is idle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 17 | Word address |
| wdata | input | 32 | Write data |
| be | input | 4 | Byte enables, bit i for byte lane i |
| rdata | output | 32 | Read data, disabled lanes zero |
| done | output | 1 | One-cycle pulse at the end of an access |
| mem_addr | output | 17 | Memory address |
| mem_sel_n | output | 4 | Active-low lane selects |
| mem_wr_n | output | 4 | Active-low lane write strobes |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dout | output | 32 | Data toward the memory |
| mem_drive | output | 1 | Enable of the controller's data drivers |
| mem_din | input | 32 | Data from the memory |

## Verification
The bench builds the controller with its default values: 17 address bits, four 8-bit lanes, a two-cycle write strobe, a two-cycle read window and one turnaround cycle. At these values the lowest and highest word addresses can be reached directly, and random byte enables cover all sixteen lane patterns. The latency of both access kinds can also be checked against the fixed counts that follow from the parameters. A model of the memory in the bench reacts only to the pin levels. It writes a byte on a rising strobe and drives the bus only for a selected lane that is reading, so lane masking, strobe timing and bus turnaround are judged from the pins alone.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int ADDR_W   = 17,
  parameter int LANES    = 4,
  parameter int LANE_W   = 8,
  parameter int WR_CYC   = 2,
  parameter int RD_CYC   = 2,
  parameter int TURN_CYC = 1,
  localparam int DW      = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [LANES-1:0]  be,
  output logic [DW-1:0]     rdata,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_sel_n,
  output logic [LANES-1:0]  mem_wr_n,
  output logic              mem_oe_n,
  output logic [DW-1:0]     mem_dout,
  output logic              mem_drive,
  input  logic [DW-1:0]     mem_din
);

  localparam int MAXC = (WR_CYC > RD_CYC) ? ((WR_CYC > TURN_CYC) ? WR_CYC : TURN_CYC)
                                          : ((RD_CYC > TURN_CYC) ? RD_CYC : TURN_CYC);
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_WRITE, S_WEND, S_TURN, S_READ} state_t;

  state_t            state;
  logic [CW-1:0]     cnt;
  logic [LANES-1:0]  lane_en;
  logic [DW-1:0]     lane_mask;

  for (genvar i = 0; i < LANES; i++) begin : g_mask
    assign lane_mask[i*LANE_W +: LANE_W] = {LANE_W{lane_en[i]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      lane_en   <= '0;
      rdata     <= '0;
      done      <= 1'b0;
      mem_addr  <= '0;
      mem_sel_n <= '1;
      mem_wr_n  <= '1;
      mem_oe_n  <= 1'b1;
      mem_dout  <= '0;
      mem_drive <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (req) begin
          mem_addr  <= addr;
          lane_en   <= be;
          mem_sel_n <= ~be;
          cnt       <= '0;
          if (we) begin
            mem_wr_n  <= ~be;
            mem_dout  <= wdata;
            mem_drive <= 1'b1;
            state     <= S_WRITE;
          end else begin
            state <= S_TURN;
          end
        end
        S_WRITE: if (cnt == CW'(WR_CYC - 1)) begin
          mem_wr_n <= '1;
          state    <= S_WEND;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_WEND: begin
          mem_sel_n <= '1;
          mem_drive <= 1'b0;
          done      <= 1'b1;
          state     <= S_IDLE;
        end
        S_TURN: if (cnt == CW'(TURN_CYC - 1)) begin
          mem_oe_n <= 1'b0;
          cnt      <= '0;
          state    <= S_READ;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_READ: if (cnt == CW'(RD_CYC - 1)) begin
          rdata     <= mem_din & lane_mask;
          mem_sel_n <= '1;
          mem_oe_n  <= 1'b1;
          done      <= 1'b1;
          state     <= S_IDLE;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int ADDR_W = 17,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     done,
  input logic [ADDR_W-1:0]        mem_addr,
  input logic [LANES-1:0]         mem_sel_n,
  input logic [LANES-1:0]         mem_wr_n,
  input logic                     mem_oe_n,
  input logic [LANES*LANE_W-1:0]  mem_dout,
  input logic                     mem_drive
);

  p_wr_in_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((~mem_wr_n) & mem_sel_n) == '0);

  p_no_drive_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_drive |-> mem_oe_n);

  p_no_wr_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_n != '1) |-> mem_oe_n);

  p_turnaround_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_drive));

  p_wr_end_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(mem_wr_n & ~$past(mem_wr_n))) |-> ($stable(mem_addr) && $stable(mem_dout) && mem_drive));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;
  localparam int AW = 17, NL = 4, LW = 8, DW = 32;
  localparam int WRC = 2, RDC = 2, TRC = 1;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [NL-1:0] be = '0;
  logic [DW-1:0] rdata, mem_dout, mem_din;
  logic done, mem_oe_n, mem_drive;
  logic [AW-1:0] mem_addr;
  logic [NL-1:0] mem_sel_n, mem_wr_n;

  sram_lane_ctrl #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW), .WR_CYC(WRC), .RD_CYC(RDC), .TURN_CYC(TRC))
    i_sram_lane_ctrl (.clk, .rst_n, .req, .we, .addr, .wdata, .be, .rdata, .done,
                      .mem_addr, .mem_sel_n, .mem_wr_n, .mem_oe_n, .mem_dout, .mem_drive, .mem_din);

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [DW-1:0] mem_store [int];
  logic [DW-1:0] ref_store [int];
  logic [NL-1:0] op_be = '0;
  bit busy = 0;

  function automatic logic [DW-1:0] seed_word(int a);
    return 32'h9E37_79B9 * (a + 1);
  endfunction
  function automatic logic [DW-1:0] mem_get(int a);
    return mem_store.exists(a) ? mem_store[a] : seed_word(a);
  endfunction
  function automatic logic [DW-1:0] ref_get(int a);
    return ref_store.exists(a) ? ref_store[a] : seed_word(a);
  endfunction
  function automatic logic [DW-1:0] expand(logic [NL-1:0] b);
    logic [DW-1:0] m;
    for (int i = 0; i < NL; i++) m[i*LW +: LW] = {LW{b[i]}};
    return m;
  endfunction

  task automatic check(bit ok, string rq, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  always @* begin
    logic [DW-1:0] cur;
    cur = mem_get(int'(mem_addr));
    for (int l = 0; l < NL; l++)
      mem_din[l*LW +: LW] = (!mem_sel_n[l] && mem_wr_n[l] && !mem_oe_n) ? cur[l*LW +: LW] : 8'hEE;
  end

  logic [NL-1:0] p_wr = '1;
  logic [AW-1:0] p_addr = '0;
  logic [DW-1:0] p_dout = '0;
  logic p_oe = 1;
  int off_cnt = 100, wr_low = 0;

  always @(negedge clk) if (rst_n) begin
    logic [NL-1:0] rise;
    logic [DW-1:0] w;
    if (mem_drive && !mem_oe_n) check(0, "R4 drive with oe low", 1, 0);
    if (mem_wr_n != '1 && !mem_oe_n) check(0, "R4 strobe with oe low", {28'd0, mem_wr_n}, 32'hF);
    if (((~mem_wr_n) & mem_sel_n) != '0) check(0, "R3 strobe outside select", {28'd0, mem_wr_n}, {28'd0, mem_sel_n});
    if (busy && (((~mem_sel_n) & ~op_be) != '0)) check(0, "R10 disabled lane selected", {28'd0, ~mem_sel_n}, {28'd0, op_be});
    if (p_oe && !mem_oe_n) check(off_cnt >= TRC, "R5 turnaround before oe", off_cnt, TRC);
    rise = mem_wr_n & ~p_wr;
    if (rise != '0) begin
      check(wr_low == WRC, "R3 strobe width", wr_low, WRC);
      check((mem_sel_n & rise) == '0, "R3 select held at strobe rise", {28'd0, mem_sel_n}, 0);
      check(mem_addr == p_addr && mem_dout == p_dout && mem_drive, "R6 stable at strobe rise", mem_dout, p_dout);
      w = mem_get(int'(p_addr));
      for (int l = 0; l < NL; l++) if (rise[l] && !mem_sel_n[l]) w[l*LW +: LW] = p_dout[l*LW +: LW];
      mem_store[int'(p_addr)] = w;
    end
    wr_low = (mem_wr_n != '1) ? wr_low + 1 : 0;
    off_cnt = mem_drive ? 0 : off_cnt + 1;
    p_wr = mem_wr_n; p_addr = mem_addr; p_dout = mem_dout; p_oe = mem_oe_n;
  end

  task automatic do_op(bit w, logic [AW-1:0] a, logic [DW-1:0] d, logic [NL-1:0] b);
    int lat;
    @(negedge clk);
    check(done == 0, "R8 done single cycle", done, 0);
    req = 1; we = w; addr = a; wdata = d; be = b; op_be = b; busy = 1;
    @(posedge clk); #1 req = 0;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!done && lat < 50);
    busy = 0;
    check(lat == (w ? WRC + 2 : TRC + RDC + 1), w ? "R8 write latency" : "R8 read latency", lat, w ? WRC + 2 : TRC + RDC + 1);
    if (w) ref_store[int'(a)] = (ref_get(int'(a)) & ~expand(b)) | (d & expand(b));
    else check(rdata == (ref_get(int'(a)) & expand(b)), "R7 R2 read data", rdata, ref_get(int'(a)) & expand(b));
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(mem_sel_n == '1 && mem_wr_n == '1 && mem_oe_n && !mem_drive && !done, "R1 reset outputs",
          {mem_sel_n, mem_wr_n, 22'd0, mem_oe_n, mem_drive}, {8'hFF, 22'd0, 2'b10});
    rst_n = 1;
    @(negedge clk);
    check(mem_sel_n == '1 && mem_wr_n == '1 && mem_oe_n && !mem_drive && !done, "R1 after reset",
          {mem_sel_n, mem_wr_n, 24'd0}, {8'hFF, 24'd0});

    do_op(1, 17'h00000, 32'hDEAD_BEEF, 4'hF);
    do_op(0, 17'h00000, 0, 4'hF);
    do_op(1, 17'h1FFFF, 32'h1234_5678, 4'b0101);
    do_op(0, 17'h1FFFF, 0, 4'hF);
    do_op(0, 17'h1FFFF, 0, 4'b0010);
    do_op(1, 17'h00010, 32'hCAFE_F00D, 4'h0);
    do_op(0, 17'h00010, 0, 4'h0);
    do_op(0, 17'h00010, 0, 4'hF);
    for (int l = 0; l < NL; l++) begin
      do_op(1, 17'h00020, 32'hA0B1_C2D3 + l, 4'b1 << l);
      do_op(0, 17'h00020, 0, 4'hF);
    end

    // R9: request held high during a write, aimed at another address
    begin
      int pulses = 0;
      @(negedge clk);
      req = 1; we = 1; addr = 17'h00040; wdata = 32'h5555_AAAA; be = 4'hF; op_be = 4'hF; busy = 1;
      @(posedge clk); #1 addr = 17'h00041; wdata = 32'h0F0F_0F0F;
      for (int c = 0; c < WRC + 2; c++) begin
        @(negedge clk);
        if (done) begin pulses++; req = 0; end
      end
      busy = 0;
      repeat (3) @(negedge clk);
      check(pulses == 1 && !done, "R9 one done for held request", pulses, 1);
      ref_store[32'h40] = 32'h5555_AAAA;
      do_op(0, 17'h00041, 0, 4'hF);
      do_op(0, 17'h00040, 0, 4'hF);
    end

    for (int n = 0; n < 500; n++) begin
      logic [AW-1:0] a;
      a = ($urandom % 4 == 0) ? AW'($urandom) : AW'($urandom % 24);
      do_op($urandom % 2 == 1, a, $urandom, NL'($urandom));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule